// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between a CPU bus and the memories of a plug-in cartridge. The CPU cannot write the read-only program space, so the block treats CPU writes below address 0x8000 as commands. It keeps the currently mapped program ROM bank, the external RAM bank, a RAM enable flag and a clock-register select. The surrounding memory path reads these as plain outputs and turns them into array addresses.

Four command dialects are supported, chosen by a static `ctrl_kind` input:
- kind 0: five ROM bank bits plus a two-bit field that serves either the ROM or the RAM bank, steered by a mode bit.
- kind 1: a four-bit ROM bank type, decoded from address bit 8.
- kind 2: a seven-bit ROM bank type with a clock select field and a clock-latch strobe.
- kind 3: a nine-bit ROM bank type.

Two static inputs give the cartridge ROM and RAM sizes as base-2 logarithms of their bank counts. Every command result is masked to those sizes.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While `rst_n` is low and until the next write after release, `rom_bank` is 1, `ram_bank` is 0, `ram_en` is 0, `clk_sel` is 0, `clk_latch` is 0 and the kind-0 mode bit is 0.
- R2: A write to the RAM-enable range sets `ram_en` to 1 when `wr_data[3:0]` is 0xA, and clears it for any other value. For kinds 0, 2 and 3 that range is 0x0000–0x1FFF. For kind 1 it is any address below 0x8000 with bit 8 clear.
- R3: Kind 0, write to 0x2000–0x3FFF: ROM bank bits 4:0 take `wr_data[4:0]`, with 0 replaced by 1. Bits 6:5 are kept and bits 8:7 are cleared.
- R4: Kind 0: a write to 0x6000–0x7FFF sets the mode bit from `wr_data[0]`. A write to 0x4000–0x5FFF sets `ram_bank` to `wr_data[1:0]` when mode is 1. When mode is 0, the same write sets ROM bank bits 6:5 to `wr_data[1:0]`.
- R5: Kind 1: a write whose address satisfies (addr & 0xE100) == 0x2100 sets `rom_bank` to `wr_data[3:0]` with no zero remap. Other writes with address bit 8 set change nothing.
- R6: Kind 2: a write to 0x2000–0x3FFF sets `rom_bank` to `wr_data[6:0]`, with 0 replaced by 1. A write to 0x4000–0x5FFF sets `clk_sel` to `wr_data[3:0]` and `ram_bank` to `wr_data[1:0]`.
- R7: Kind 2: a write to 0x6000–0x7FFF raises `clk_latch` for exactly the one cycle after the write edge. Writes for any other kind or range leave it low.
- R8: Kind 3: 0x2000–0x2FFF sets ROM bank bits 7:0 from `wr_data`, with 0 replaced by 1. 0x3000–0x3FFF sets bit 8 from `wr_data[0]`. 0x4000–0x5FFF sets `ram_bank` to `wr_data[3:0]`.
- R9: After every command, `rom_bank` is ANDed with 2^`rom_log2`−1 and `ram_bank` with 2^`ram_log2`−1. Later partial updates start from the masked value.
- R10: A cycle with `wr_en` low, or a write with address bit 15 set, leaves every output unchanged and `clk_latch` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_kind | input | 2 | Static controller dialect, 0 to 3 |
| rom_log2 | input | 4 | log2 of the cartridge ROM bank count (0 to 9) |
| ram_log2 | input | 3 | log2 of the cartridge RAM bank count (0 to 4) |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rom_bank | output | 9 | Mapped switchable ROM bank |
| ram_bank | output | 4 | Mapped external RAM bank |
| ram_en | output | 1 | External RAM access enabled |
| clk_sel | output | 4 | Clock register select (kind 2) |
| clk_latch | output | 1 | One-cycle clock latch strobe (kind 2) |

## Verification
The design is built with its default widths. The size inputs are swept at run time: full sizes (9 ROM bits, 4 RAM bits) for every kind, then small sizes (8 ROM banks, 2 RAM banks) and a single ROM bank.

The small sizes show that masking applies after each command and that later partial updates start from the masked value. The single-bank case shows that masking can override the zero-to-one remap. The full sizes reach the top ROM bits of the nine-bit and seven-bit dialects, as well as both uses of the two-bit field in kind 0.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int ROM_W = 9;
  localparam int RAM_W = 4;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    KIND_5P2   = 2'd0,
    KIND_4B    = 2'd1,
    KIND_7BCLK = 2'd2,
    KIND_9B    = 2'd3
  } cbc_kind_e;

  typedef struct packed {
    logic [ROM_W-1:0] rom;
    logic [RAM_W-1:0] ram;
    logic             en;
    logic             mode;
    logic [SEL_W-1:0] sel;
  } cbc_state_t;
endpackage

// File: rtl/cbc_rst_sync.sv
module cbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cbc_cmd_decode.sv
module cbc_cmd_decode
  import cbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  cbc_state_t        cur,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ROM_W-1:0]  rom_mask,
  input  logic [RAM_W-1:0]  ram_mask,
  output cbc_state_t        nxt,
  output logic              latch_req
);
  localparam int NIB_LO = ADDR_W - 4;

  logic [3:0] region;
  logic       en_val;
  logic [4:0] lo5;
  logic [6:0] lo7;
  logic [7:0] lo8;

  always_comb begin
    region = addr[ADDR_W-1:NIB_LO];
    en_val = (data[3:0] == 4'hA);
    lo5    = (data[4:0] == 5'd0) ? 5'd1 : data[4:0];
    lo7    = (data[6:0] == 7'd0) ? 7'd1 : data[6:0];
    lo8    = (data[7:0] == 8'd0) ? 8'd1 : data[7:0];
  end

  always_comb begin
    nxt       = cur;
    latch_req = 1'b0;
    if (!region[3]) begin
      unique case (cbc_kind_e'(kind))
        KIND_5P2: begin
          unique case (region[2:1])
            2'd0: nxt.en = en_val;
            2'd1: nxt.rom = {2'b00, cur.rom[6:5], lo5};
            2'd2: begin
              if (cur.mode) nxt.ram = {{(RAM_W-2){1'b0}}, data[1:0]};
              else          nxt.rom = {2'b00, data[1:0], cur.rom[4:0]};
            end
            default: nxt.mode = data[0];
          endcase
        end
        KIND_4B: begin
          if (!addr[8])
            nxt.en = en_val;
          else if ((addr[ADDR_W-2:ADDR_W-3] == 2'b01) && (addr[8] == 1'b1))
            nxt.rom = {{(ROM_W-4){1'b0}}, data[3:0]};
        end
        KIND_7BCLK: begin
          unique case (region[2:1])
            2'd0: nxt.en = en_val;
            2'd1: nxt.rom = {2'b00, lo7};
            2'd2: begin
              nxt.sel = data[3:0];
              nxt.ram = {{(RAM_W-2){1'b0}}, data[1:0]};
            end
            default: latch_req = 1'b1;
          endcase
        end
        default: begin
          unique case (region[2:0])
            3'd0, 3'd1: nxt.en = en_val;
            3'd2:       nxt.rom = {cur.rom[8], lo8};
            3'd3:       nxt.rom = {data[0], cur.rom[7:0]};
            3'd4, 3'd5: nxt.ram = data[3:0];
            default: ;
          endcase
        end
      endcase
      nxt.rom = nxt.rom & rom_mask;
      nxt.ram = nxt.ram & ram_mask;
    end
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctrl_kind,
  input  logic [3:0]        rom_log2,
  input  logic [2:0]        ram_log2,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ROM_W-1:0]  rom_bank,
  output logic [RAM_W-1:0]  ram_bank,
  output logic              ram_en,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              clk_latch
);
  localparam cbc_state_t RESET_STATE = '{rom: ROM_W'(1), ram: '0, en: 1'b0, mode: 1'b0, sel: '0};

  logic                rst_sync_n;
  logic [ROM_W-1:0]    rom_mask;
  logic [RAM_W-1:0]    ram_mask;
  cbc_state_t          state_q, state_d, dec_nxt;
  logic                latch_q, latch_d, dec_latch;
  logic                cmd_ce;

  cbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    for (int i = 0; i < ROM_W; i++) rom_mask[i] = (i < int'(rom_log2));
    for (int j = 0; j < RAM_W; j++) ram_mask[j] = (j < int'(ram_log2));
  end

  cbc_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .cur       (state_q),
    .kind      (ctrl_kind),
    .addr      (wr_addr),
    .data      (wr_data),
    .rom_mask  (rom_mask),
    .ram_mask  (ram_mask),
    .nxt       (dec_nxt),
    .latch_req (dec_latch)
  );

  always_comb begin
    cmd_ce  = wr_en && !wr_addr[ADDR_W-1];
    state_d = cmd_ce ? dec_nxt : state_q;
    latch_d = cmd_ce && dec_latch;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= RESET_STATE;
      latch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      latch_q <= latch_d;
    end
  end

  assign rom_bank  = state_q.rom;
  assign ram_bank  = state_q.ram;
  assign ram_en    = state_q.en;
  assign clk_sel   = state_q.sel;
  assign clk_latch = latch_q;
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
  import cbc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       ctrl_kind,
  input logic [3:0]       rom_log2,
  input logic [2:0]       ram_log2,
  input logic             wr_en,
  input logic [15:0]      wr_addr,
  input logic [7:0]       wr_data,
  input logic [ROM_W-1:0] rom_bank,
  input logic [RAM_W-1:0] ram_bank,
  input logic             ram_en,
  input logic [SEL_W-1:0] clk_sel,
  input logic             clk_latch
);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr[15]) |=> ($stable(rom_bank) && $stable(ram_bank) &&
                                 $stable(ram_en) && $stable(clk_sel) && !clk_latch));

  assert_rom_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[15]) |=> ((rom_bank >> rom_log2) == '0) && ((ram_bank >> ram_log2) == '0));

  assert_latch_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_latch |-> (ctrl_kind == 2'd2) && $past(wr_en) && ($past(wr_addr[15:13]) == 3'b011));

  assert_enable_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:13] == 3'b000 && ctrl_kind != 2'd1 && wr_data[3:0] == 4'hA) |=> ram_en);

  assert_seven_rom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_kind == 2'd2 && wr_en && wr_addr[15:13] == 3'b001 && wr_data[6:0] != 7'd0 && rom_log2 >= 4'd7)
      |=> (rom_bank == {2'b00, $past(wr_data[6:0])}));

  assert_nine_ram_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_kind == 2'd3 && wr_en && wr_addr[15:13] == 3'b010 && ram_log2 >= 3'd4)
      |=> (ram_bank == $past(wr_data[3:0])));
endmodule

bind cart_bank_ctrl cbc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_kind (ctrl_kind),
  .rom_log2  (rom_log2),
  .ram_log2  (ram_log2),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rom_bank  (rom_bank),
  .ram_bank  (ram_bank),
  .ram_en    (ram_en),
  .clk_sel   (clk_sel),
  .clk_latch (clk_latch)
);

// File: tb/sim_cart_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctrl_kind = 2'd0;
  logic [3:0]  rom_log2 = 4'd9;
  logic [2:0]  ram_log2 = 3'd4;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = 16'h0;
  logic [7:0]  wr_data = 8'h0;
  logic [8:0]  rom_bank;
  logic [3:0]  ram_bank;
  logic        ram_en;
  logic [3:0]  clk_sel;
  logic        clk_latch;

  typedef struct {
    logic [8:0] rom;
    logic [3:0] ram;
    logic       en;
    logic [3:0] sel;
    logic       lat;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [8:0] m_rom;
  logic [3:0] m_ram, m_sel;
  logic       m_en, m_mode;

  always #4 clk = ~clk;

  cart_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_kind(ctrl_kind), .rom_log2(rom_log2),
    .ram_log2(ram_log2), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en),
    .clk_sel(clk_sel), .clk_latch(clk_latch)
  );

  function automatic logic [8:0] rmask();
    return 9'((10'd1 << rom_log2) - 10'd1);
  endfunction
  function automatic logic [3:0] amask();
    return 4'((5'd1 << ram_log2) - 5'd1);
  endfunction

  // Reference behaviour taken from the requirements
  task automatic model_write(input logic [15:0] a, input logic [7:0] d,
                             output logic lat, output string tag);
    lat = 1'b0;
    tag = "R10";
    if (!a[15]) begin
      case (ctrl_kind)
        2'd0: begin
          case (a[14:13])
            2'd0: begin m_en = (d[3:0] == 4'hA); tag = "R2"; end
            2'd1: begin m_rom = {2'b00, m_rom[6:5], (d[4:0] == 0) ? 5'd1 : d[4:0]}; tag = "R3"; end
            2'd2: begin
              if (m_mode) m_ram = {2'b00, d[1:0]};
              else        m_rom = {2'b00, d[1:0], m_rom[4:0]};
              tag = "R4";
            end
            default: begin m_mode = d[0]; tag = "R4"; end
          endcase
        end
        2'd1: begin
          if (!a[8]) begin m_en = (d[3:0] == 4'hA); tag = "R2"; end
          else if ((a & 16'hE100) == 16'h2100) begin m_rom = {5'd0, d[3:0]}; tag = "R5"; end
          else tag = "R5";
        end
        2'd2: begin
          case (a[14:13])
            2'd0: begin m_en = (d[3:0] == 4'hA); tag = "R2"; end
            2'd1: begin m_rom = {2'b00, (d[6:0] == 0) ? 7'd1 : d[6:0]}; tag = "R6"; end
            2'd2: begin m_sel = d[3:0]; m_ram = {2'b00, d[1:0]}; tag = "R6"; end
            default: begin lat = 1'b1; tag = "R7"; end
          endcase
        end
        default: begin
          case (a[14:12])
            3'd0, 3'd1: begin m_en = (d[3:0] == 4'hA); tag = "R2"; end
            3'd2: begin m_rom = {m_rom[8], (d == 0) ? 8'd1 : d}; tag = "R8"; end
            3'd3: begin m_rom = {d[0], m_rom[7:0]}; tag = "R8"; end
            3'd4, 3'd5: begin m_ram = d[3:0]; tag = "R8"; end
            default: tag = "R8";
          endcase
        end
      endcase
      m_rom = m_rom & rmask();
      m_ram = m_ram & amask();
      if (rom_log2 < 4'd9 || ram_log2 < 3'd4) tag = {tag, "/R9"};
    end
  endtask

  task automatic push_exp(input logic lat, input string tag);
    exp_t e;
    e.rom = m_rom; e.ram = m_ram; e.en = m_en; e.sel = m_sel; e.lat = lat; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(input logic we, input logic [15:0] a, input logic [7:0] d);
    logic  lat;
    string tag;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (we) model_write(a, d, lat, tag);
    else begin lat = 1'b0; tag = "R10"; end
    push_exp(lat, tag);
  endtask

  task automatic do_reset(input logic [1:0] k, input logic [3:0] rl, input logic [2:0] al);
    @(negedge clk);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    ctrl_kind = k; rom_log2 = rl; ram_log2 = al;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m_rom = 9'd1; m_ram = 4'd0; m_en = 1'b0; m_mode = 1'b0; m_sel = 4'd0;
    push_exp(1'b0, "R1");
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'($urandom);
      d = 8'($urandom);
      if (($urandom % 10) < 8) a[15] = 1'b0;
      if (ctrl_kind == 2'd1 && ($urandom % 2) == 0) a = (a & ~16'hE100) | 16'h2100;
      if (($urandom % 8) == 0) d = 8'h00;
      if (($urandom % 8) == 1) d[3:0] = 4'hA;
      drive(($urandom % 6) != 0, a, d);
    end
  endtask

  // Monitor: compares the design against the oldest expected item
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rom_bank !== e.rom || ram_bank !== e.ram || ram_en !== e.en ||
          clk_sel !== e.sel || clk_latch !== e.lat) begin
        fails++;
        $display("FAIL %s: got rom=%h ram=%h en=%b sel=%h lat=%b, expected rom=%h ram=%h en=%b sel=%h lat=%b",
                 e.tag, rom_bank, ram_bank, ram_en, clk_sel, clk_latch,
                 e.rom, e.ram, e.en, e.sel, e.lat);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Kind 0, full sizes: R1, R2, R3, R4, R10
    do_reset(2'd0, 4'd9, 3'd4);
    drive(1'b1, 16'h2000, 8'h00);  // R3 zero remap -> 1
    drive(1'b1, 16'h4000, 8'h03);  // R4 mode 0 -> rom 0x61
    drive(1'b1, 16'h6000, 8'h01);  // R4 mode 1
    drive(1'b1, 16'h5FFF, 8'h02);  // R4 ram 2
    drive(1'b1, 16'h3FFF, 8'h1F);  // R3 keeps bits 6:5 -> 0x7F
    drive(1'b1, 16'h0000, 8'h0A);  // R2 enable
    drive(1'b1, 16'h1000, 8'h1A);  // R2 low nibble only
    drive(1'b1, 16'h0100, 8'h0B);  // R2 disable
    drive(1'b1, 16'h8000, 8'h05);  // R10 upper half ignored
    drive(1'b0, 16'h2000, 8'h05);  // R10 strobe low
    random_run(300);
    // Kind 1: R5
    do_reset(2'd1, 4'd9, 3'd4);
    drive(1'b1, 16'h2100, 8'h00);  // R5 no remap -> 0
    drive(1'b1, 16'h3100, 8'hF7);  // R5 -> 7
    drive(1'b1, 16'h4100, 8'h03);  // R5 no match
    drive(1'b1, 16'h4000, 8'h0A);  // R2 bit 8 clear
    random_run(300);
    // Kind 2: R6, R7
    do_reset(2'd2, 4'd9, 3'd4);
    drive(1'b1, 16'h2000, 8'h80);  // R6 zero remap -> 1
    drive(1'b1, 16'h2000, 8'h7F);  // R6 -> 0x7F
    drive(1'b1, 16'h4000, 8'h0B);  // R6 sel 0xB, ram 3
    drive(1'b1, 16'h6000, 8'h01);  // R7 latch pulse
    drive(1'b0, 16'h6000, 8'h01);  // R7 pulse gone
    random_run(300);
    // Kind 3: R8
    do_reset(2'd3, 4'd9, 3'd4);
    drive(1'b1, 16'h2000, 8'h00);  // R8 remap -> 1
    drive(1'b1, 16'h3000, 8'h01);  // R8 bit 8 -> 0x101
    drive(1'b1, 16'h2FFF, 8'hFF);  // R8 -> 0x1FF
    drive(1'b1, 16'h4000, 8'h0E);  // R8 ram 0xE
    random_run(300);
    // Small sizes: R9
    do_reset(2'd0, 4'd3, 3'd1);
    drive(1'b1, 16'h2000, 8'h1F);  // R9 -> 7
    drive(1'b1, 16'h4000, 8'h03);  // R9 bits 6:5 masked away
    drive(1'b1, 16'h6000, 8'h01);
    drive(1'b1, 16'h4000, 8'h03);  // R9 ram -> 1
    random_run(200);
    do_reset(2'd3, 4'd0, 3'd0);
    drive(1'b1, 16'h2000, 8'h00);  // R9 single bank -> 0
    random_run(100);
    do_reset(2'd2, 4'd5, 3'd2);
    random_run(200);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule